// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory with a shared bidirectional data bus. Each access is captured on a rising clock edge. A read passes through a registered output stage, so the word appears on the bus one full cycle after the cycle in which its address was taken. The block is meant to sit behind a processor or memory controller that streams short bursts of four words.

There are two address strobes. A host-side strobe starts a read burst and is only honoured while the primary chip enable is active. A controller-side strobe can start either a read or a write. A burst-advance input steps a two-bit linear counter through the four words that share the upper address bits, and holding it inactive keeps the burst on the current word.

Writes go to whole words or to individual byte lanes, according to a global write input, a byte-write gate and one enable per lane. Three chip enables decide on every address load whether the device is selected. An asynchronous output enable controls the bus direction. A sleep input freezes the device and releases the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held, and after it is released with no access started, `dq` is high-impedance and no burst is active.
- R2: An address load happens when `procStrobeN` is low together with `chipEnN` low, or when `ctrlStrobeN` is low. A low `procStrobeN` while `chipEnN` is high is ignored: the running burst continues as if no strobe were present. The device is selected after a load only if `chipEnN`=0, `chipEn2`=1 and `chipEn3N`=0. A load with any of these inactive deselects it.
- R3: A read whose address is captured at clock edge k drives the stored word on `dq` from just after edge k+1 until edge k+2, provided `outEnN` is low.
- R4: During a selected burst with no load, `advanceN` low sets the low two address bits to (previous value + 1) modulo 4. `advanceN` high keeps them unchanged. The upper address bits keep the loaded value, so four advances return to the loaded address.
- R5: The three chip enables are not looked at during burst continuation cycles. Deasserting them there neither stops nor changes the burst.
- R6: In the cycle that follows the edge where a deselected device becomes selected, `dq` is high-impedance.
- R7: `outEnN` acts without a clock. While it is high, `dq` is high-impedance at once, and the pending read word reappears as soon as it returns low.
- R8: The write decode works as follows. If `globalWrN` is low, all lanes are written. Otherwise, if `byteWrEnN` is low, each lane i with `byteEnN[i]` low is written, where lane i is `dq[9*i+8:9*i]`. If neither condition selects a lane, the cycle is a read.
- R9: On a load by `procStrobeN`, the write inputs are ignored and the cycle is a read of the loaded address. Writes requested on the following continuation cycles take effect at the current burst address.
- R10: On a load by `ctrlStrobeN` that requests a write, the word on `dq` at that same edge is written at the loaded address, according to the R8 lane decode.
- R11: While `sleep` is high, `dq` is high-impedance and every strobe, address, enable and write input is ignored. Memory contents and burst state are the same after waking as before sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except outEnN and sleep effects are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control and pipeline state |
| addrIn | input | ADDR_W | Word address taken on a load |
| procStrobeN | input | 1 | Host-side address strobe, active low, read-only start |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low; high suspends on the current word |
| chipEnN | input | 1 | Primary chip enable, active low; also gates procStrobeN |
| chipEn2 | input | 1 | Second chip enable, active high |
| chipEn3N | input | 1 | Third chip enable, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Byte-write gate, active low |
| byteEnN | input | NBYTES | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high; only raised while deselected |
| dq | inout | NBYTES*BYTE_W | Shared data bus |

## Verification
A behavioural model in the bench predicts the bus on every clock and compares it with the design. Isolated reads started by each strobe check the two-cycle latency and the high-impedance first cycle after selection. Four-word bursts that begin off a burst boundary, include a suspended cycle and run past the fourth word check the modulo-4 stepping and the wrap, as opposed to a plain binary increment that would carry into the upper bits. Chip enables dropped in mid-burst and a host strobe given while the primary enable is off tell ignored inputs apart from real loads. Partial-lane, empty-lane and global writes, host-strobe cycles that carry write requests, output-enable pulses between edges, and strobes given during sleep are each read back, to show which lanes changed and that the ignored requests changed nothing.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  // strobes from the control into the datapath for the access taken this edge
  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PROC = 2'd1,
    LD_CTRL = 2'd2
  } load_e;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [NBYTES-1:0] byteEnN,
  output acc_t              acc,
  output logic [ADDR_W-1:0] accAddr,
  output logic [NBYTES-1:0] accMask,
  output logic              active
);
  localparam int UP_W = ADDR_W - 2;

  logic            activeQ, activeD;
  logic [UP_W-1:0] upQ, upD;
  logic [1:0]      lowQ, lowD;
  load_e           ldKind;
  logic            selNow;
  logic [NBYTES-1:0] wMask;
  logic            hasWrite;

  // which strobe, if any, loads an address this edge
  always_comb begin
    if (sleep)                          ldKind = LD_NONE;
    else if (!procStrobeN && !chipEnN)  ldKind = LD_PROC;
    else if (!ctrlStrobeN)              ldKind = LD_CTRL;
    else                                ldKind = LD_NONE;
  end

  assign selNow   = !chipEnN && chipEn2 && !chipEn3N;
  assign wMask    = !globalWrN ? {NBYTES{1'b1}} : (!byteWrEnN ? ~byteEnN : '0);
  assign hasWrite = |wMask;

  always_comb begin
    acc     = '0;
    accMask = '0;
    activeD = activeQ;
    upD     = upQ;
    lowD    = lowQ;
    accAddr = {upQ, lowQ};
    if (ldKind != LD_NONE) begin
      activeD = selNow;
      if (selNow) begin
        upD     = addrIn[ADDR_W-1:2];
        lowD    = addrIn[1:0];
        accAddr = addrIn;
        if (ldKind == LD_CTRL && hasWrite) begin
          acc.wr  = 1'b1;
          accMask = wMask;
        end else begin
          acc.rd  = 1'b1;
        end
      end
    end else if (!sleep && activeQ) begin
      lowD    = advanceN ? lowQ : lowQ + 2'd1;
      accAddr = {upQ, lowD};
      if (hasWrite) begin
        acc.wr  = 1'b1;
        accMask = wMask;
      end else begin
        acc.rd  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      upQ     <= '0;
      lowQ    <= '0;
    end else begin
      activeQ <= activeD;
      upQ     <= upD;
      lowQ    <= lowD;
    end
  end

  assign active = activeQ;

  // R4: upper address bits hold across a continuation cycle
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && ldKind == LD_NONE && !sleep) |=> (upQ == $past(upQ)));

  // R5: a continuation cycle never drops selection
  assert_ce_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && ldKind == LD_NONE && !sleep) |=> activeQ);

  // R9: host-strobe load never issues a write
  assert_proc_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ldKind == LD_PROC) |-> !acc.wr);
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              outEnN,
  input  acc_t              acc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [NBYTES-1:0] accMask,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              dqOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              stgRd, stgWr, outValid;
  logic [ADDR_W-1:0] stgAddr;
  logic [NBYTES-1:0] stgMask;
  logic [DATA_W-1:0] stgData;

  // input stage: one access per cycle, write data taken with its command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgRd    <= 1'b0;
      stgWr    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      stgRd    <= acc.rd;
      stgWr    <= acc.wr;
      outValid <= stgRd && !sleep;
    end
  end

  always_ff @(posedge clk) begin
    stgAddr <= accAddr;
    stgMask <= accMask;
    stgData <= dqIn;
  end

  // one storage array per byte lane, each with its own output register
  for (genvar g = 0; g < NBYTES; g++) begin : gLane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (stgWr && stgMask[g])
        laneMem[stgAddr] <= stgData[g*BYTE_W +: BYTE_W];
      if (stgRd)
        laneQ <= laneMem[stgAddr];
    end
    assign rdData[g*BYTE_W +: BYTE_W] = laneQ;
  end

  assign dqOe = outValid && !outEnN && !sleep;

  // R3: data on the output register comes from a read captured two edges earlier
  assert_read_pipe_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(acc.rd, 2));

  // R8: a cycle is a read or a write, never both
  assert_one_op_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(acc.rd && acc.wr));
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEnN,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [NBYTES-1:0] byteEnN,
  input  logic              outEnN,
  input  logic              sleep,
  inout  wire  [DATA_W-1:0] dq
);
  acc_t              acc;
  logic [ADDR_W-1:0] accAddr;
  logic [NBYTES-1:0] accMask;
  logic              active;
  logic [DATA_W-1:0] rdData;
  logic              dqOe;

  burst_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .addrIn(addrIn), .chipEnN(chipEnN), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteEnN(byteEnN),
    .acc(acc), .accAddr(accAddr), .accMask(accMask), .active(active)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sleep(sleep), .outEnN(outEnN),
    .acc(acc), .accAddr(accAddr), .accMask(accMask),
    .dqIn(dq), .rdData(rdData), .dqOe(dqOe)
  );

  assign dq = dqOe ? rdData : {DATA_W{1'bz}};

  // R6: bus released in the first cycle after becoming selected
  assert_first_cycle_z_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> !dqOe);

  // R11: no access leaves the control while asleep
  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !(acc.rd || acc.wr));
endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 4;
  localparam int BYTE_W = 9;
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN;
  logic [ADDR_W-1:0] addrIn;
  logic procStrobeN, ctrlStrobeN, advanceN;
  logic chipEnN, chipEn2, chipEn3N;
  logic globalWrN, byteWrEnN;
  logic [NBYTES-1:0] byteEnN;
  logic outEnN, sleep;
  logic [DATA_W-1:0] tbData;
  logic tbDrvEn;
  wire  [DATA_W-1:0] dq;

  assign dq = tbDrvEn ? tbData : {DATA_W{1'bz}};

  always #10 clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_sync_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipEnN(chipEnN), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteEnN(byteEnN),
    .outEnN(outEnN), .sleep(sleep), .dq(dq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [DATA_W-1:0] mMem [DEPTH];
  bit mActive = 0;
  int mUp = 0, mLow = 0;
  bit sRd = 0, sWr = 0;
  int sAddr = 0;
  logic [NBYTES-1:0] sMask = '0;
  logic [DATA_W-1:0] sData = '0;
  bit oValid = 0;
  logic [DATA_W-1:0] oData = '0;

  function automatic logic [DATA_W-1:0] pat(input int a);
    return DATA_W'(a * 36'h0_1357_9BDF + 36'h5_A5A5_A5A5);
  endfunction

  task automatic modelEdge();
    logic [NBYTES-1:0] mask;
    bit procLd, ctrlLd, sel;
    if (!rstN) begin
      mActive = 0; sRd = 0; sWr = 0; oValid = 0;
      return;
    end
    // finish the access staged on the previous edge
    if (sRd) oData = mMem[sAddr];
    if (sWr)
      for (int b = 0; b < NBYTES; b++)
        if (sMask[b]) mMem[sAddr][b*BYTE_W +: BYTE_W] = sData[b*BYTE_W +: BYTE_W];
    oValid = sRd && !sleep;
    // decode the access presented now
    sRd = 0; sWr = 0;
    sData = dq;
    if (!globalWrN) mask = '1;
    else if (!byteWrEnN) mask = ~byteEnN;
    else mask = '0;
    if (!sleep) begin
      procLd = !procStrobeN && !chipEnN;
      ctrlLd = !procLd && !ctrlStrobeN;
      sel = !chipEnN && chipEn2 && !chipEn3N;
      if (procLd || ctrlLd) begin
        mActive = sel;
        if (sel) begin
          mUp = int'(addrIn) / 4;
          mLow = int'(addrIn) % 4;
          sAddr = int'(addrIn);
          if (ctrlLd && mask != 0) begin sWr = 1; sMask = mask; end
          else sRd = 1;
        end
      end else if (mActive) begin
        if (!advanceN) mLow = (mLow + 1) % 4;
        sAddr = mUp * 4 + mLow;
        if (mask != 0) begin sWr = 1; sMask = mask; end
        else sRd = 1;
      end
    end
  endtask

  task automatic checkDq(input string tag);
    logic [DATA_W-1:0] exp;
    if (tbDrvEn) return;
    exp = (oValid && !outEnN && !sleep) ? oData : {DATA_W{1'bz}};
    checks++;
    if (dq !== exp) begin
      errors++;
      $display("FAIL %s: dq actual=%h expected=%h at %0t", tag, dq, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    #1;
    checkDq(tag);
  endtask

  task automatic setIdle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    chipEnN = 0; chipEn2 = 1; chipEn3N = 0;
    globalWrN = 1; byteWrEnN = 1; byteEnN = '1;
    outEnN = 0; sleep = 0; tbDrvEn = 0; tbData = '0; addrIn = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    setIdle();
    rstN = 0;
    repeat (3) tick("R1");
    rstN = 1;
    tick("R1");
    tick("R1");

    // R10: fill every word with controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) begin
      setIdle(); ctrlStrobeN = 0; addrIn = ADDR_W'(a); globalWrN = 0;
      outEnN = 1; tbData = pat(a); tbDrvEn = 1;
      tick("R10");
    end

    // R6: deselect, then select with a read of word 9
    setIdle(); ctrlStrobeN = 0; chipEn2 = 0; tick("R6");
    setIdle(); tick("R6"); tick("R6");
    setIdle(); ctrlStrobeN = 0; addrIn = 9; tick("R6");
    setIdle(); tick("R6");
    tick("R3"); tick("R3");

    // R4: host-strobe burst from word 14 with suspend and wrap
    setIdle(); procStrobeN = 0; addrIn = 14; tick("R4");
    setIdle(); advanceN = 0; repeat (3) tick("R4");
    advanceN = 1; tick("R4");
    advanceN = 0; repeat (3) tick("R4");

    // R5: chip enables dropped during continuation
    setIdle(); advanceN = 0; chipEn3N = 1; chipEn2 = 0; tick("R5"); tick("R5");

    // R2: host strobe with primary enable off is ignored
    setIdle(); advanceN = 0; procStrobeN = 0; chipEnN = 1; tick("R2"); tick("R2");
    // R2: controller-strobe load of word 40
    setIdle(); ctrlStrobeN = 0; addrIn = 40; tick("R2");
    setIdle(); advanceN = 0; tick("R2"); tick("R2");
    // R2: controller-strobe load with third enable off deselects
    setIdle(); ctrlStrobeN = 0; chipEn3N = 1; addrIn = 3; tick("R2");
    setIdle(); tick("R2"); tick("R2");

    // R8: lanes 0 and 2 at word 20, empty mask at 21, global write at 22
    setIdle(); ctrlStrobeN = 0; addrIn = 20; byteWrEnN = 0; byteEnN = 4'b1010;
    outEnN = 1; tbData = 36'hF_0F0F_0F0F; tbDrvEn = 1; tick("R8");
    setIdle(); ctrlStrobeN = 0; addrIn = 21; byteWrEnN = 0; byteEnN = 4'b1111;
    outEnN = 1; tbData = 36'h0_1234_5678; tbDrvEn = 1; tick("R8");
    setIdle(); ctrlStrobeN = 0; addrIn = 22; globalWrN = 0; byteWrEnN = 1;
    outEnN = 1; tbData = 36'hA_BCDE_F012; tbDrvEn = 1; tick("R8");
    for (int a = 20; a < 23; a++) begin
      setIdle(); ctrlStrobeN = 0; addrIn = ADDR_W'(a); tick("R8");
    end
    setIdle(); tick("R8"); tick("R8");

    // R9: host-strobe load carrying a write request stays a read
    setIdle(); procStrobeN = 0; addrIn = 32; globalWrN = 0;
    outEnN = 1; tbData = 36'h1_1111_1111; tbDrvEn = 1; tick("R9");
    setIdle(); globalWrN = 0; outEnN = 1; tbData = 36'h2_2222_2222; tbDrvEn = 1; tick("R9");
    setIdle(); globalWrN = 0; advanceN = 0; outEnN = 1; tbData = 36'h3_3333_3333; tbDrvEn = 1;
    tick("R9");
    setIdle(); ctrlStrobeN = 0; addrIn = 32; tick("R9");
    setIdle(); advanceN = 0; repeat (4) tick("R9");

    // R7: output enable pulsed between edges
    setIdle(); tick("R7");
    outEnN = 1; #1; checkDq("R7");
    outEnN = 0; #1; checkDq("R7");
    tick("R7");

    // R11: sleep while deselected; strobes and writes must change nothing
    setIdle(); ctrlStrobeN = 0; chipEn2 = 0; tick("R11");
    setIdle(); tick("R11"); tick("R11");
    sleep = 1; tick("R11");
    ctrlStrobeN = 0; addrIn = 0; globalWrN = 0; outEnN = 1; tbData = 36'hD_EAD0_BEEF; tbDrvEn = 1;
    tick("R11"); tick("R11");
    tbDrvEn = 0; ctrlStrobeN = 1; globalWrN = 1; outEnN = 0;
    procStrobeN = 0; addrIn = 1; tick("R11"); tick("R11");
    setIdle(); tick("R11");
    setIdle(); ctrlStrobeN = 0; addrIn = 0; tick("R11");
    setIdle(); advanceN = 0; repeat (4) tick("R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule